// File: doc/BRIEF.md
# MMU Fault Syndrome Capture Unit

This block takes the result of a translation lookup and turns it into either a physical address or a recorded fault. Each request carries a virtual address, an access kind, a translation-enable flag, a probe flag and the lookup outcome. The lookup outcome is a hit, a protection fault or a miss, and a hit comes with the matching entry's virtual page, physical page and permissions. With translation enabled, a hit produces a physical address. With translation disabled, the address passes through unchanged with every permission granted. The response appears one cycle after the request.

When a fault is not a probe, the block captures the full faulting virtual address and a syndrome word. The syndrome code depends on the fault kind and on whether the access was an instruction fetch, and a separate flag bit marks stores. The block then raises an exception request that stays high until the exception logic acknowledges it. A probe fault only reports failure. A second real fault that arrives while an exception is still unacknowledged sets a sticky fatal error and leaves the first fault's record in place.

Top module: `mmu_fault_capture`

## Requirements
- R1: After reset, every output is zero.
- R2: With `req_xlat_en`=0, the response has `rsp_ok`=1, `rsp_paddr` equal to `req_vaddr` and `rsp_perm` all ones, whatever the lookup result; no fault or probe failure follows.
- R3: With translation on and `lk_result`=2'b00 (hit), `rsp_ok`=1 and `rsp_perm`=`lk_perm`. The page field of `rsp_paddr` equals `lk_ppage` + (page field of `req_vaddr`) − `lk_vpage`, modulo the page-field width, and the low log2(PAGE_SIZE) offset bits come straight from `req_vaddr`.
- R4: A protection fault (`lk_result`=2'b01) writes syndrome code 17 in bits [4:0] for an instruction fetch (`req_kind`=2'b00) and 16 for any data access.
- R5: A miss (`lk_result`=2'b10, and also 2'b11) writes code 19 for an instruction fetch and 16+2=18 for a data access.
- R6: Syndrome bit 10 is set only when the faulting access is a store (`req_kind`=2'b10). All other syndrome bits outside [4:0] are zero.
- R7: For a non-probe fault, the edge after the request pulses `fault_valid` for one cycle. On that same edge it loads `fault_addr` with the full virtual address and raises `exc_req`. A failing response has `rsp_ok`=0 and `rsp_paddr` and `rsp_perm` zero.
- R8: A fault with `req_probe`=1 pulses `probe_fail`. It leaves `fault_addr`, `fault_syndrome` and `exc_req` unchanged and does not pulse `fault_valid`.
- R9: `exc_req` stays high until a cycle with `exc_ack`=1. A fault accepted in the same cycle as `exc_ack` keeps it high and counts as a fresh fault.
- R10: A non-probe fault while `exc_req` is high and `exc_ack` is low sets `recursive_err`, which stays set until reset. That fault does not pulse `fault_valid`, and the earlier fault's address and syndrome are kept.
- R11: `rsp_valid` pulses one cycle after each `req_valid`. In cycles with no response, `rsp_ok`, `rsp_paddr` and `rsp_perm` are zero.
- R12: `req_kind`=2'b11 is handled exactly as a data load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_vaddr | input | AW | Virtual address |
| req_kind | input | 2 | 00 fetch, 01 load, 10 store, 11 load |
| req_xlat_en | input | 1 | Translation enabled |
| req_probe | input | 1 | Probe-only lookup |
| lk_result | input | 2 | 00 hit, 01 protection fault, 10/11 miss |
| lk_vpage | input | AW-log2(PAGE_SIZE) | Hit entry virtual page |
| lk_ppage | input | AW-log2(PAGE_SIZE) | Hit entry physical page |
| lk_perm | input | PERM_W | Hit entry permissions |
| exc_ack | input | 1 | Exception taken, clears request |
| rsp_valid | output | 1 | Response pulse |
| rsp_ok | output | 1 | Translation succeeded |
| rsp_paddr | output | AW | Physical address |
| rsp_perm | output | PERM_W | Granted permissions |
| probe_fail | output | 1 | Probe lookup failed |
| fault_valid | output | 1 | Fault captured pulse |
| exc_req | output | 1 | Pending MMU exception |
| fault_addr | output | AW | Captured faulting address |
| fault_syndrome | output | 32 | Captured syndrome word |
| recursive_err | output | 1 | Sticky recursive-fault error |

## Verification
The bench builds the block with AW=16, PAGE_SIZE=16 and PERM_W=3, so the page field is 12 bits and the offset is 4 bits. At that size, one sweep covers every combination of translation flag, probe flag, access kind and lookup code, including the reserved encodings. Page arithmetic that wraps past the 12-bit page field is reached with modest base values. Separate sequences drive the acknowledge-coincident fault and the recursive-fault case.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

  localparam int SYN_W      = 32;
  localparam int STORE_BIT  = 10;
  localparam int CODE_W     = 5;
  localparam int CODE_BASE  = 16;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'b00,
    ACC_LOAD  = 2'b01,
    ACC_STORE = 2'b10,
    ACC_ALT   = 2'b11
  } acc_kind_e;

  typedef enum logic [1:0] {
    LK_HIT  = 2'b00,
    LK_PROT = 2'b01,
    LK_MISS = 2'b10,
    LK_ALT  = 2'b11
  } lk_res_e;

  typedef struct packed {
    logic ok;
    logic fault;
    logic miss;
    logic fetch;
    logic store;
    logic perm_all;
  } verdict_t;

  function automatic logic [CODE_W-1:0] fault_code(input logic is_miss,
                                                    input logic is_fetch);
    logic [CODE_W-1:0] c;
    c = CODE_W'(CODE_BASE);
    c[1] = is_miss;
    c[0] = is_fetch;
    return c;
  endfunction

  function automatic logic [SYN_W-1:0] make_syndrome(input logic is_miss,
                                                      input logic is_fetch,
                                                      input logic is_store);
    logic [SYN_W-1:0] s;
    s = '0;
    s[CODE_W-1:0] = fault_code(is_miss, is_fetch);
    s[STORE_BIT]  = is_store;
    return s;
  endfunction

endpackage

// File: rtl/fsc_classify.sv
module fsc_classify
  import fsc_pkg::*;
(
  input  logic [1:0] kind,
  input  logic [1:0] result,
  input  logic       xlat_en,
  output verdict_t   verdict
);

  acc_kind_e kind_e;
  lk_res_e   res_e;

  assign kind_e = acc_kind_e'(kind);
  assign res_e  = lk_res_e'(result);

  always_comb begin
    verdict          = '0;
    verdict.fetch    = (kind_e == ACC_FETCH);
    verdict.store    = (kind_e == ACC_STORE);
    if (!xlat_en) begin
      verdict.ok       = 1'b1;
      verdict.perm_all = 1'b1;
    end else begin
      unique case (res_e)
        LK_HIT:  verdict.ok = 1'b1;
        LK_PROT: verdict.fault = 1'b1;
        LK_MISS, LK_ALT: begin
          verdict.fault = 1'b1;
          verdict.miss  = 1'b1;
        end
        default: verdict.fault = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/fsc_xlate.sv
module fsc_xlate #(
  parameter int AW    = 32,
  parameter int OFF_W = 12,
  localparam int PG_W = AW - OFF_W
) (
  input  logic [AW-1:0]   vaddr,
  input  logic [PG_W-1:0] vpage,
  input  logic [PG_W-1:0] ppage,
  input  logic            xlat_en,
  output logic [AW-1:0]   paddr
);

  function automatic logic [PG_W-1:0] relocate(input logic [PG_W-1:0] va_pg,
                                                input logic [PG_W-1:0] ent_v,
                                                input logic [PG_W-1:0] ent_p);
    return ent_p + va_pg - ent_v;
  endfunction

  logic [PG_W-1:0] mapped_pg;

  assign mapped_pg = relocate(vaddr[AW-1:OFF_W], vpage, ppage);
  assign paddr     = xlat_en ? {mapped_pg, vaddr[OFF_W-1:0]} : vaddr;

endmodule

// File: rtl/fsc_capture.sv
module fsc_capture
  import fsc_pkg::*;
#(
  parameter int AW     = 32,
  parameter int PERM_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_probe,
  input  logic [AW-1:0]     req_vaddr,
  input  logic [AW-1:0]     xl_paddr,
  input  logic [PERM_W-1:0] lk_perm,
  input  verdict_t          verdict,
  input  logic              exc_ack,
  output logic              evt_capture,
  output logic              evt_probe_fail,
  output logic              evt_recursive,
  output logic              rsp_valid,
  output logic              rsp_ok,
  output logic [AW-1:0]     rsp_paddr,
  output logic [PERM_W-1:0] rsp_perm,
  output logic              probe_fail,
  output logic              fault_valid,
  output logic              exc_req,
  output logic [AW-1:0]     fault_addr,
  output logic [SYN_W-1:0]  fault_syndrome,
  output logic              recursive_err
);

  logic fault_now;
  logic real_fault;

  assign fault_now      = req_valid & verdict.fault;
  assign evt_probe_fail = fault_now & req_probe;
  assign real_fault     = fault_now & ~req_probe;
  assign evt_recursive  = real_fault & exc_req & ~exc_ack;
  assign evt_capture    = real_fault & ~evt_recursive;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
      rsp_paddr <= '0;
      rsp_perm  <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid && verdict.ok) begin
        rsp_ok    <= 1'b1;
        rsp_paddr <= xl_paddr;
        rsp_perm  <= verdict.perm_all ? {PERM_W{1'b1}} : lk_perm;
      end else begin
        rsp_ok    <= 1'b0;
        rsp_paddr <= '0;
        rsp_perm  <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault_valid    <= 1'b0;
      probe_fail     <= 1'b0;
      exc_req        <= 1'b0;
      recursive_err  <= 1'b0;
      fault_addr     <= '0;
      fault_syndrome <= '0;
    end else begin
      fault_valid   <= evt_capture;
      probe_fail    <= evt_probe_fail;
      exc_req       <= (exc_req & ~exc_ack) | evt_capture;
      recursive_err <= recursive_err | evt_recursive;
      if (evt_capture) begin
        fault_addr     <= req_vaddr;
        fault_syndrome <= make_syndrome(verdict.miss, verdict.fetch, verdict.store);
      end
    end
  end

endmodule

// File: rtl/mmu_fault_capture.sv
module mmu_fault_capture
  import fsc_pkg::*;
#(
  parameter int AW        = 32,
  parameter int PAGE_SIZE = 4096,
  parameter int PERM_W    = 3,
  localparam int OFF_W    = $clog2(PAGE_SIZE),
  localparam int PG_W     = AW - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [AW-1:0]     req_vaddr,
  input  logic [1:0]        req_kind,
  input  logic              req_xlat_en,
  input  logic              req_probe,
  input  logic [1:0]        lk_result,
  input  logic [PG_W-1:0]   lk_vpage,
  input  logic [PG_W-1:0]   lk_ppage,
  input  logic [PERM_W-1:0] lk_perm,
  input  logic              exc_ack,
  output logic              rsp_valid,
  output logic              rsp_ok,
  output logic [AW-1:0]     rsp_paddr,
  output logic [PERM_W-1:0] rsp_perm,
  output logic              probe_fail,
  output logic              fault_valid,
  output logic              exc_req,
  output logic [AW-1:0]     fault_addr,
  output logic [SYN_W-1:0]  fault_syndrome,
  output logic              recursive_err
);

  verdict_t        verdict;
  logic [AW-1:0]   xl_paddr;
  logic            evt_capture;
  logic            evt_probe_fail;
  logic            evt_recursive;

  fsc_classify u_classify (
    .kind    (req_kind),
    .result  (lk_result),
    .xlat_en (req_xlat_en),
    .verdict (verdict)
  );

  fsc_xlate #(.AW(AW), .OFF_W(OFF_W)) u_xlate (
    .vaddr   (req_vaddr),
    .vpage   (lk_vpage),
    .ppage   (lk_ppage),
    .xlat_en (req_xlat_en),
    .paddr   (xl_paddr)
  );

  fsc_capture #(.AW(AW), .PERM_W(PERM_W)) u_capture (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_probe      (req_probe),
    .req_vaddr      (req_vaddr),
    .xl_paddr       (xl_paddr),
    .lk_perm        (lk_perm),
    .verdict        (verdict),
    .exc_ack        (exc_ack),
    .evt_capture    (evt_capture),
    .evt_probe_fail (evt_probe_fail),
    .evt_recursive  (evt_recursive),
    .rsp_valid      (rsp_valid),
    .rsp_ok         (rsp_ok),
    .rsp_paddr      (rsp_paddr),
    .rsp_perm       (rsp_perm),
    .probe_fail     (probe_fail),
    .fault_valid    (fault_valid),
    .exc_req        (exc_req),
    .fault_addr     (fault_addr),
    .fault_syndrome (fault_syndrome),
    .recursive_err  (recursive_err)
  );

endmodule

// File: rtl/fsc_checker.sv
module fsc_checker
  import fsc_pkg::*;
#(
  parameter int AW     = 32,
  parameter int PERM_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [AW-1:0]     req_vaddr,
  input logic [1:0]        req_kind,
  input logic              req_xlat_en,
  input logic              exc_ack,
  input logic              evt_capture,
  input logic              evt_probe_fail,
  input logic              evt_recursive,
  input logic              rsp_valid,
  input logic              rsp_ok,
  input logic [AW-1:0]     rsp_paddr,
  input logic [PERM_W-1:0] rsp_perm,
  input logic              probe_fail,
  input logic              fault_valid,
  input logic              exc_req,
  input logic [AW-1:0]     fault_addr,
  input logic [SYN_W-1:0]  fault_syndrome,
  input logic              recursive_err
);

  AST_BYPASS_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_xlat_en) |=> (rsp_ok && rsp_paddr == $past(req_vaddr) && rsp_perm == {PERM_W{1'b1}})); // R2

  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> (fault_syndrome[4:0] >= 5'd16 && fault_syndrome[4:0] <= 5'd19)); // R4

  AST_STORE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    evt_capture |=> (fault_syndrome[STORE_BIT] == ($past(req_kind) == 2'b10))); // R6

  AST_CAPTURE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    evt_capture |=> (fault_valid && exc_req && fault_addr == $past(req_vaddr))); // R7

  AST_RECORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_valid |-> ($stable(fault_addr) && $stable(fault_syndrome))); // R7

  AST_PROBE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    evt_probe_fail |-> !evt_capture && !evt_recursive); // R8

  AST_PROBE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    probe_fail |-> !fault_valid); // R8

  AST_EXC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && !exc_ack) |=> exc_req); // R9

  AST_EXC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_ack && !evt_capture) |=> !exc_req); // R9

  AST_RECUR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    recursive_err |=> recursive_err); // R10

  AST_RECUR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    evt_recursive |=> (recursive_err && !fault_valid)); // R10

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R11

  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_ok && rsp_paddr == '0 && rsp_perm == '0)); // R11

endmodule

bind mmu_fault_capture fsc_checker #(.AW(AW), .PERM_W(PERM_W)) u_fsc_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_vaddr      (req_vaddr),
  .req_kind       (req_kind),
  .req_xlat_en    (req_xlat_en),
  .exc_ack        (exc_ack),
  .evt_capture    (evt_capture),
  .evt_probe_fail (evt_probe_fail),
  .evt_recursive  (evt_recursive),
  .rsp_valid      (rsp_valid),
  .rsp_ok         (rsp_ok),
  .rsp_paddr      (rsp_paddr),
  .rsp_perm       (rsp_perm),
  .probe_fail     (probe_fail),
  .fault_valid    (fault_valid),
  .exc_req        (exc_req),
  .fault_addr     (fault_addr),
  .fault_syndrome (fault_syndrome),
  .recursive_err  (recursive_err)
);

// File: tb/mmu_fault_capture_test.sv
module mmu_fault_capture_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW     = 16;
  localparam int PSIZE  = 16;
  localparam int PERM_W = 3;
  localparam int OFF_W  = 4;
  localparam int PG_W   = AW - OFF_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic [AW-1:0]     req_vaddr = '0;
  logic [1:0]        req_kind = '0;
  logic              req_xlat_en = 1'b0;
  logic              req_probe = 1'b0;
  logic [1:0]        lk_result = '0;
  logic [PG_W-1:0]   lk_vpage = '0;
  logic [PG_W-1:0]   lk_ppage = '0;
  logic [PERM_W-1:0] lk_perm = '0;
  logic              exc_ack = 1'b0;
  logic              rsp_valid, rsp_ok, probe_fail, fault_valid, exc_req, recursive_err;
  logic [AW-1:0]     rsp_paddr, fault_addr;
  logic [PERM_W-1:0] rsp_perm;
  logic [31:0]       fault_syndrome;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [AW-1:0] m_addr = '0;
  logic [31:0]   m_syn  = '0;
  bit            m_pend = 1'b0;
  bit            m_rec  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mmu_fault_capture #(.AW(AW), .PAGE_SIZE(PSIZE), .PERM_W(PERM_W)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_kind(req_kind), .req_xlat_en(req_xlat_en), .req_probe(req_probe),
    .lk_result(lk_result), .lk_vpage(lk_vpage), .lk_ppage(lk_ppage),
    .lk_perm(lk_perm), .exc_ack(exc_ack), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
    .rsp_paddr(rsp_paddr), .rsp_perm(rsp_perm), .probe_fail(probe_fail),
    .fault_valid(fault_valid), .exc_req(exc_req), .fault_addr(fault_addr),
    .fault_syndrome(fault_syndrome), .recursive_err(recursive_err)
  );

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // one request; outputs sampled at the next falling edge
  task automatic access(logic [AW-1:0] va, int kind, int res, bit xl, bit pr,
                        int vpg, int ppg, int perm, bit ack);
    bit is_fault, real_f, recur, miss, fetch, store;
    int pg;
    logic [AW-1:0] exp_pa;
    logic [31:0] code;
    req_valid = 1'b1; req_vaddr = va; req_kind = 2'(kind); lk_result = 2'(res);
    req_xlat_en = xl; req_probe = pr; lk_vpage = PG_W'(vpg); lk_ppage = PG_W'(ppg);
    lk_perm = PERM_W'(perm); exc_ack = ack;
    is_fault = xl && (res != 0);
    real_f   = is_fault && !pr;
    recur    = real_f && m_pend && !ack;
    miss     = (res >= 2);
    fetch    = (kind == 0);
    store    = (kind == 2);
    @(negedge clk);
    req_valid = 1'b0; exc_ack = 1'b0;
    if (!xl) exp_pa = va;
    else begin
      pg = ((int'(va) >> OFF_W) - vpg + ppg) & ((1 << PG_W) - 1);
      exp_pa = AW'((pg << OFF_W) | (int'(va) % PSIZE));
    end
    code = 32'(16 + (miss ? 2 : 0) + (fetch ? 1 : 0)) + (store ? 32'd1024 : 32'd0);
    if (ack) m_pend = 1'b0;
    if (recur) m_rec = 1'b1;
    else if (real_f) begin m_pend = 1'b1; m_addr = va; m_syn = code; end
    check("R11 rsp_valid", rsp_valid, 1);
    check(xl ? "R3 rsp_ok" : "R2 rsp_ok", rsp_ok, !is_fault);
    check(xl ? "R3 rsp_paddr" : "R2 rsp_paddr", rsp_paddr, is_fault ? 0 : exp_pa);
    check("R3 rsp_perm", rsp_perm, is_fault ? 0 : (xl ? perm : 7));
    check("R8 probe_fail", probe_fail, is_fault && pr);
    check("R7 fault_valid", fault_valid, real_f && !recur);
    check("R9 exc_req", exc_req, m_pend);
    check("R10 recursive_err", recursive_err, m_rec);
    check("R7 fault_addr", fault_addr, m_addr);
    check(miss ? "R5 syndrome" : "R4 syndrome", fault_syndrome, m_syn);
  endtask

  task automatic ack_now();
    exc_ack = 1'b1;
    @(negedge clk);
    exc_ack = 1'b0;
    m_pend = 1'b0;
    check("R9 exc_req cleared", exc_req, 0);
    check("R11 idle rsp_ok", rsp_ok, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual expired expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rsp_valid", rsp_valid, 0);
    check("R1 exc_req", exc_req, 0);
    check("R1 fault_syndrome", fault_syndrome, 0);
    check("R1 fault_addr", fault_addr, 0);
    check("R1 recursive_err", recursive_err, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // full sweep: flag x probe x kind x result (R2..R8, R12)
    for (int xl = 0; xl < 2; xl++)
      for (int pr = 0; pr < 2; pr++)
        for (int k = 0; k < 4; k++)
          for (int r = 0; r < 4; r++) begin
            int idx = ((xl * 2 + pr) * 4 + k) * 4 + r;
            logic [AW-1:0] va = AW'(idx * 16'h0937 + 16'h1234);
            access(va, k, r, xl[0], pr[0], (idx * 37) & 12'hfff,
                   (idx * 211 + 5) & 12'hfff, idx % 8, 1'b0);
            if (m_pend) ack_now();
          end

    // R12: reserved kind matches load on miss and protection
    access(16'hbeef, 3, 2, 1'b1, 1'b0, 0, 0, 0, 1'b0);
    check("R12 kind11 syndrome", fault_syndrome, 18);
    ack_now();
    access(16'h0420, 3, 1, 1'b1, 1'b0, 0, 0, 0, 1'b0);
    check("R12 kind11 prot", fault_syndrome, 16);
    ack_now();

    // R3 page wrap: vpage larger than vaddr page
    access(16'h0015, 1, 0, 1'b1, 1'b0, 12'h010, 12'h005, 5, 1'b0);
    check("R3 wrap paddr", rsp_paddr, 16'hff65);

    // R9: fault coincident with ack is a fresh capture
    access(16'h1111, 0, 2, 1'b1, 1'b0, 0, 0, 0, 1'b0);
    access(16'h2222, 2, 1, 1'b1, 1'b0, 0, 0, 0, 1'b1);
    check("R9 ack+fault exc_req", exc_req, 1);
    check("R6 store syndrome", fault_syndrome, 32'h410);

    // R8: probe fault while pending leaves everything alone
    access(16'h3333, 0, 2, 1'b1, 1'b1, 0, 0, 0, 1'b0);
    check("R8 probe keeps addr", fault_addr, 16'h2222);

    // R10: recursive fault
    access(16'h4444, 0, 2, 1'b1, 1'b0, 0, 0, 0, 1'b0);
    check("R10 recursive set", recursive_err, 1);
    check("R10 first addr kept", fault_addr, 16'h2222);
    check("R10 first syndrome kept", fault_syndrome, 32'h410);
    ack_now();
    access(16'h5555, 1, 1, 1'b1, 1'b0, 0, 0, 0, 1'b0);
    check("R10 sticky", recursive_err, 1);
    check("R7 new capture", fault_addr, 16'h5555);
    ack_now();

    // R11: idle cycles produce no response
    repeat (2) @(negedge clk);
    check("R11 idle rsp_valid", rsp_valid, 0);
    check("R11 idle paddr", rsp_paddr, 0);
    finish_run();
  end

endmodule